// File: doc/BRIEF.md
# Dynamic Voltage Setpoint Slew Controller

This block generates the 7-bit reference code that feeds a buck regulator's DAC. The output voltage this code represents is 0.600 V plus 6.25 mV per code step. Code 0 stands for 0.600 V, code 80 for 1.100 V and code 127 for 1.39375 V. Two programmed setpoints are held outside the block. An external select pin picks which one is the live target.

When the target lies above the present code, the code climbs one step at a time. The pace comes from a free-running time base, divided by a power-of-two prescaler set by a 3-bit rate field. When the target lies below the present code, the block does not ramp. It raises a switching-inhibit output and holds the code. When a comparator reports that the output has discharged to the new level, it loads the target in one step.

Two flags report upward and downward transitions that are in progress. A mode output reports forced PWM or auto PFM/PWM. The select pin chooses which of two mode bits applies.

The block is built around a four-state machine:
- `ST_OFF` (regulator disabled),
- `ST_HOLD` (code equals target),
- `ST_RISE` (stepping upward),
- `ST_FALL` (inhibited, waiting for discharge).

On each clock edge the next state is chosen by comparing the updated code with the target:
- below the target gives `ST_RISE`,
- above the target gives `ST_FALL`,
- equal gives `ST_HOLD`,
- with enable low, `ST_OFF` is taken from any state.

Top module: `dvs_slew_ctrl`

## Requirements
- R1: After reset the code equals START_CODE (default 0). The rise flag, fall flag and switching-inhibit output are all low.
- R2: With the select pin low the target is `code_lo`. With the pin high it is `code_hi`. Once settled, `dac_code` equals the selected target.
- R3: During a rise the code increases by exactly one every 2^`slew` tick cycles. `slew`=0 gives one step per tick and `slew`=7 gives one step per 128 ticks. The first step comes 2^`slew` ticks after the rise begins.
- R4: Clock cycles without `tick` high do not advance the code or the prescaler.
- R5: When the target is below the code, `sw_inhibit` and `ramp_down` go high one edge later and the code holds. On the first edge with `out_reached` high, the code loads the target, and `sw_inhibit` and `ramp_down` fall on that same edge.
- R6: `ramp_up` is high while a rise has not reached its target. It drops on the edge where the code reaches the target. Both flags are registered from the code and target of the previous edge.
- R7: `forced_pwm` equals `mode[0]` when the select pin is low and `mode[1]` when it is high, where 1 means forced PWM and 0 means auto PFM/PWM.
- R8: A target change during a rise is taken from the present code. A new target below the code turns the transition into an inhibited fall on the next edge.
- R9: With `enable` low, the next edge forces the code to START_CODE and clears `ramp_up`, `ramp_down` and `sw_inhibit`.
- R10: A target of 127 is reached and held with no wrap of the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Regulator enabled |
| sel_pin | input | 1 | Setpoint select: 0 picks code_lo, 1 picks code_hi |
| code_lo | input | 7 | Setpoint used with select low |
| code_hi | input | 7 | Setpoint used with select high |
| slew | input | 3 | Rise-rate field; step every 2^slew ticks |
| mode | input | 2 | Mode bits; bit0 for select low, bit1 for select high |
| tick | input | 1 | Time-base strobe, one per fastest step interval |
| out_reached | input | 1 | Comparator: output has fallen to target |
| dac_code | output | 7 | Reference code to the DAC |
| sw_inhibit | output | 1 | Hold off switching during a fall |
| ramp_up | output | 1 | Upward transition in progress |
| ramp_down | output | 1 | Downward transition in progress |
| forced_pwm | output | 1 | 1 forced PWM, 0 auto PFM/PWM |

## Verification
Stepping and retargeting can land in the same cycle. This happens when the target drops below a code that is mid-ramp while the prescaler is about to fire. The bench provokes it by lowering the setpoint during a fast rise. It then judges that the code stays put rather than taking one more step, and that the inhibit output rises on the next edge. A discharge that completes while the setpoint is still moving is handled the same way: loading the target must clear both flags on the same edge.

// File: rtl/dvs_pkg.sv
package dvs_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_RISE = 2'd2,
        ST_FALL = 2'd3
    } dvs_state_t;
endpackage

// File: rtl/dvs_target_sel.sv
module dvs_target_sel #(
    parameter int CODE_W = 7
) (
    input  logic              sel_pin,
    input  logic [CODE_W-1:0] code_lo,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [1:0]        mode,
    output logic [CODE_W-1:0] target,
    output logic              forced_pwm
);
    // The select pin chooses both the setpoint and the mode bit that applies.
    always_comb begin
        target     = sel_pin ? code_hi : code_lo;
        forced_pwm = sel_pin ? mode[1] : mode[0];
    end
endmodule

// File: rtl/dvs_step_timer.sv
module dvs_step_timer #(
    parameter int SLEW_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic [SLEW_W-1:0] slew,
    output logic              step
);
    localparam int PRE_W = (1 << SLEW_W) - 1;

    logic [PRE_W-1:0] cnt_q;
    logic [PRE_W-1:0] limit;

    // The limit is 2^slew - 1, and a step fires when the count reaches it.
    always_comb begin
        limit = (PRE_W'(1) << slew) - PRE_W'(1);
        step  = run && tick && (cnt_q >= limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (tick)    cnt_q <= step ? '0 : cnt_q + PRE_W'(1);
    end

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt_q) || cnt_q == '0); // R4
endmodule

// File: rtl/dvs_slew_ctrl.sv
module dvs_slew_ctrl #(
    parameter int CODE_W     = 7,
    parameter int SLEW_W     = 3,
    parameter int START_CODE = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              sel_pin,
    input  logic [CODE_W-1:0] code_lo,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [SLEW_W-1:0] slew,
    input  logic [1:0]        mode,
    input  logic              tick,
    input  logic              out_reached,
    output logic [CODE_W-1:0] dac_code,
    output logic              sw_inhibit,
    output logic              ramp_up,
    output logic              ramp_down,
    output logic              forced_pwm
);
    import dvs_pkg::*;

    localparam logic [CODE_W-1:0] START = CODE_W'(START_CODE);

    dvs_state_t        state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic [CODE_W-1:0] target;
    logic              rise_req;
    logic              step;

    dvs_target_sel #(.CODE_W(CODE_W)) u_sel (
        .sel_pin    (sel_pin),
        .code_lo    (code_lo),
        .code_hi    (code_hi),
        .mode       (mode),
        .target     (target),
        .forced_pwm (forced_pwm)
    );

    assign rise_req = enable && (code_q < target);

    dvs_step_timer #(.SLEW_W(SLEW_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (rise_req),
        .tick  (tick),
        .slew  (slew),
        .step  (step)
    );

    // Next code and next state: the state is taken from the updated code.
    always_comb begin
        if (!enable)
            code_d = START;
        else if (code_q < target && step)
            code_d = code_q + CODE_W'(1);
        else if (code_q > target && out_reached)
            code_d = target;
        else
            code_d = code_q;

        if (!enable)              state_d = ST_OFF;
        else if (code_d < target) state_d = ST_RISE;
        else if (code_d > target) state_d = ST_FALL;
        else                      state_d = ST_HOLD;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            code_q  <= START;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    // Outputs
    always_comb begin
        dac_code   = code_q;
        sw_inhibit = 1'b0;
        ramp_up    = 1'b0;
        ramp_down  = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_HOLD: ;
            ST_RISE: ramp_up = 1'b1;
            ST_FALL: begin
                ramp_down  = 1'b1;
                sw_inhibit = 1'b1;
            end
        endcase
    end

    AST_SINGLE_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (dac_code > $past(dac_code)) |-> ({1'b0, dac_code} == {1'b0, $past(dac_code)} + 1'b1)); // R3

    AST_FALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ramp_down && enable && !out_reached && target < dac_code) |=> $stable(dac_code)); // R5

    AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (dac_code == START && !ramp_up && !ramp_down && !sw_inhibit)); // R9

    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ramp_up && ramp_down) && (sw_inhibit == ramp_down)); // R6
endmodule

// File: tb/dvs_slew_ctrl_tb.sv
module dvs_slew_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b1;
    logic       sel_pin = 1'b0;
    logic [6:0] code_lo = '0;
    logic [6:0] code_hi = '0;
    logic [2:0] slew = '0;
    logic [1:0] mode = '0;
    logic       tick = 1'b1;
    logic       out_reached = 1'b1;
    logic [6:0] dac_code;
    logic       sw_inhibit, ramp_up, ramp_down, forced_pwm;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dvs_slew_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .sel_pin(sel_pin),
        .code_lo(code_lo), .code_hi(code_hi), .slew(slew), .mode(mode),
        .tick(tick), .out_reached(out_reached), .dac_code(dac_code),
        .sw_inhibit(sw_inhibit), .ramp_up(ramp_up), .ramp_down(ramp_down),
        .forced_pwm(forced_pwm)
    );

    // fields: sel, lo, hi, mode, expected code, expected forced_pwm
    localparam logic [24:0] VEC [0:5] = '{
        {1'b0, 7'd80, 7'd10,  2'b00, 7'd80,  1'b0},  // R2 R7
        {1'b1, 7'd80, 7'd10,  2'b10, 7'd10,  1'b1},  // R2 R7
        {1'b0, 7'd40, 7'd10,  2'b01, 7'd40,  1'b1},  // R2 R7
        {1'b1, 7'd40, 7'd127, 2'b01, 7'd127, 1'b0},  // R10 R7
        {1'b0, 7'd0,  7'd127, 2'b10, 7'd0,   1'b0},  // R2 R7
        {1'b1, 7'd0,  7'd64,  2'b11, 7'd64,  1'b1}   // R2 R7
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #1_000_000ns;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 code", dac_code, 0);
        chk("R1 flags", {ramp_up, ramp_down, sw_inhibit}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            {sel_pin, code_lo, code_hi, mode} = VEC[v][24:8];
            edges(130);
            chk("R2/R10 code", dac_code, int'(VEC[v][7:1]));
            chk("R7 mode", forced_pwm, int'(VEC[v][0]));
        end

        // R9: disable
        enable = 1'b0;
        edges(1);
        chk("R9 code", dac_code, 0);
        chk("R9 flags", {ramp_up, ramp_down, sw_inhibit}, 0);

        // R3 / R4 / R6: slow rise
        enable = 1'b1; sel_pin = 1'b0; code_lo = 7'd0; slew = 3'd2;
        out_reached = 1'b0;
        edges(2);
        code_lo = 7'd10;
        edges(10);
        chk("R3 code after 10 ticks", dac_code, 2);
        chk("R6 ramp_up high", ramp_up, 1);
        tick = 1'b0;
        edges(20);
        chk("R4 no tick hold", dac_code, 2);
        tick = 1'b1;
        edges(2);
        chk("R4 resume step", dac_code, 3);
        edges(28);
        chk("R3 reach target", dac_code, 10);
        chk("R6 ramp_up low", ramp_up, 0);

        // R3: slowest rate
        slew = 3'd7; code_lo = 7'd12;
        edges(255);
        chk("R3 slew7 one step", dac_code, 11);
        edges(1);
        chk("R3 slew7 two steps", dac_code, 12);

        // R5: fall
        code_lo = 7'd4;
        edges(5);
        chk("R5 frozen", dac_code, 12);
        chk("R5 inhibit", sw_inhibit, 1);
        chk("R5 ramp_down", ramp_down, 1);
        out_reached = 1'b1;
        edges(1);
        chk("R5 load", dac_code, 4);
        chk("R5 flags clear", {ramp_down, sw_inhibit}, 0);
        out_reached = 1'b0;

        // R8: retarget mid-rise
        slew = 3'd0; code_lo = 7'd30;
        edges(5);
        chk("R8 mid ramp", dac_code, 9);
        code_lo = 7'd6;
        edges(1);
        chk("R8 no extra step", dac_code, 9);
        chk("R8 inhibit", sw_inhibit, 1);
        chk("R8 ramp_up off", ramp_up, 0);
        out_reached = 1'b1;
        edges(1);
        chk("R8 load", dac_code, 6);

        finish_run();
    end
endmodule